// File: doc/BRIEF.md
# Memory-Mapped Storage Card Task-File Decoder

This block is the card-side register decoder for a removable flash storage card that a host drives in its memory-mapped common-memory mode. It watches the host's address lines, the register/attribute select, the two byte-lane chip enables and the read and write strobes. It sends every access either to the task-file registers or to a 512-byte sector buffer. It keeps a pointer into that buffer so that back-to-back accesses to the data port stream through the sector without the host touching any address counter.

The host sees the data port at several aliases. Two of them carry the whole data register, one carries only its odd byte, and a 1 KB window above the register block repeats the data port by address parity so that memory-to-memory block moves can be used. The pointer moves on in a different way for word transfers, for repeated even-lane byte transfers and for mixed odd/even byte transfers, and each order still walks the sector once. Writing the command register restarts the pointer at byte 0 and passes the command code, as a one-cycle pulse, to the command engine that sits behind the block.

Top module: `cfTaskDecoder`

## Requirements
- R1: With the register select high and A10 low, offsets 2, 3, 4, 5 and 6 (A9..A4 ignored) are five byte registers (count, sector, cylinder low, cylinder high, head select). Each reads back its written value and is exported on taskRegs, offset 2 at bits 7:0 and offset 6 at bits 39:32. A word access to an even/odd offset pair moves the even register on D7..0 and the odd register on D15..8.
- R2: Reading offset 7 or offset E returns statusIn. Reading offset 1 or offset D returns errorIn. Reading offset F returns driveAddrIn. Writing offset 1 or D loads the features output.
- R3: Writing offset 7 loads cmdCode, raises cmdValid for exactly one clock and returns the buffer pointer to byte 0, ready for a new sector.
- R4: Writing offset E loads devCtl. Offsets A, B and C read as 00h, and writes to them and to offset F change nothing.
- R5: A word access (both enables low) to offset 0, 1, 8 or 9 moves one 16-bit buffer word: the even byte on D7..0 and the odd byte on D15..8. Successive word accesses move successive words.
- R6: A low-lane byte access (ce1N low, ce2N high) to offset 0 or 8 moves the next byte of the sector on D7..0, even byte first and then odd byte.
- R7: A byte access to offset 9 moves only the odd byte of the current word. An 8-then-9 pair and a 9-then-8 pair each cover one word and advance the pointer once. Repeating 9 alone does not advance it.
- R8: A high-lane byte access (ce1N high, ce2N low) uses D15..8 and reaches offset (A3..A0 with bit 0 forced to 1), so address 0 reaches the error/features register and offset 8 reaches the odd data byte.
- R9: With A10 high, an even address from 400h to 7FFh behaves as offset 8 and an odd address behaves as offset 9. No task-file register is reached.
- R10: After byte 511 has moved, the pointer stops. Further data accesses neither write the buffer nor advance, and they read 0000h until the next command write.
- R11: An access takes effect once, on the clock edge that first sees its strobe low. Accesses with the register select low, or with both enables high, have no effect. The lane a byte access does not use reads 00h, and dataOut holds between reads.
- R12: After reset, dataOut, taskRegs, features, devCtl, cmdCode and cmdValid are all zero, and the pointer is at byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Active-low asynchronous reset |
| addr | input | 11 | Host address A10..A0 |
| regN | input | 1 | Register/attribute select, high for common memory |
| ce1N | input | 1 | Active-low enable of the even lane D7..0 |
| ce2N | input | 1 | Active-low enable of the odd lane D15..8 |
| oeN | input | 1 | Active-low read strobe |
| weN | input | 1 | Active-low write strobe |
| dataIn | input | 16 | Host write data |
| statusIn | input | 8 | Status byte from the command engine |
| errorIn | input | 8 | Error byte from the command engine |
| driveAddrIn | input | 8 | Drive address byte from the command engine |
| dataOut | output | 16 | Read data, held until the next read |
| taskRegs | output | 40 | Head, cylinder high, cylinder low, sector, count |
| features | output | 8 | Features register |
| devCtl | output | 8 | Device control register |
| cmdCode | output | 8 | Last command code written |
| cmdValid | output | 1 | One-clock pulse when a command is written |

## Verification
Some checks run on every cycle. They confirm that read data holds steady when there is no read edge and that the command pulse lasts exactly one clock. They also confirm that attribute-space writes and writes into the 1 KB window never disturb the task file, and that the reserved offsets read as zero. The pointer behaviour can only be seen across whole sequences of accesses, so the bench scenarios cover it: the 9-then-8 and 8-then-9 byte orders, high-lane odd bytes, the window parity aliasing, the restart on a command write and the stop after byte 511.

// File: rtl/cfdec_pkg.sv
package cfdec_pkg;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_REG  = 2'd1,
    ACC_DATA = 2'd2
  } accKindT;

  typedef enum logic [1:0] {
    DM_WORD = 2'd0,
    DM_SEQ  = 2'd1,
    DM_ODD  = 2'd2
  } dataModeT;

  // strobes from control to datapath, valid for the one cycle of an access
  typedef struct packed {
    logic     rd;
    logic     wr;
    accKindT  kind;
    dataModeT mode;
    logic     laneHi;
    logic     loEn;
    logic     hiEn;
    logic [3:0] loOff;
    logic [3:0] hiOff;
  } accStrobeT;

  localparam int OFF_W = 4;
  localparam int NUM_OFF = 1 << OFF_W;

  localparam logic [3:0] OFF_DATA    = 4'h0;
  localparam logic [3:0] OFF_ERRFEAT = 4'h1;
  localparam logic [3:0] OFF_TFBASE  = 4'h2;
  localparam logic [3:0] OFF_STATCMD = 4'h7;
  localparam logic [3:0] OFF_DUPEVEN = 4'h8;
  localparam logic [3:0] OFF_DUPODD  = 4'h9;
  localparam logic [3:0] OFF_DUPERR  = 4'hD;
  localparam logic [3:0] OFF_ALTCTL  = 4'hE;
  localparam logic [3:0] OFF_DRVADR  = 4'hF;

  localparam int TF_REGS = 5;

endpackage

// File: rtl/cfdecCtrl.sv
module cfdecCtrl
  import cfdec_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              regN,
  input  logic              ce1N,
  input  logic              ce2N,
  input  logic              oeN,
  input  logic              weN,
  output accStrobeT         acc
);

  localparam int WIN_BIT = ADDR_W - 1;

  logic oePrev, wePrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oePrev <= 1'b1;
      wePrev <= 1'b1;
    end else begin
      oePrev <= oeN;
      wePrev <= weN;
    end
  end

  logic selected, wordAcc, oddOnly, dataOff;
  logic [OFF_W-1:0] off, effOff, pairBase;

  always_comb begin
    selected = regN && !(ce1N && ce2N);
    wordAcc  = !ce1N && !ce2N;
    oddOnly  = ce1N && !ce2N;
    // window above the register block aliases the data port by parity
    off      = addr[WIN_BIT] ? {3'b100, addr[0]} : addr[OFF_W-1:0];
    effOff   = oddOnly ? (off | 4'd1) : off;
    pairBase = {off[OFF_W-1:1], 1'b0};
    if (wordAcc)
      dataOff = (pairBase == OFF_DATA) || (pairBase == OFF_DUPEVEN);
    else
      dataOff = (effOff == OFF_DATA) || (effOff == OFF_DUPEVEN) ||
                (effOff == OFF_DUPODD);

    acc        = '0;
    acc.rd     = selected && oePrev && !oeN && weN;
    acc.wr     = selected && wePrev && !weN && oeN;
    acc.laneHi = oddOnly;

    if (dataOff) begin
      acc.kind = ACC_DATA;
      if (wordAcc)                  acc.mode = DM_WORD;
      else if (effOff == OFF_DUPODD) acc.mode = DM_ODD;
      else                          acc.mode = DM_SEQ;
    end else begin
      acc.kind = ACC_REG;
      if (wordAcc) begin
        acc.loEn  = 1'b1;
        acc.hiEn  = 1'b1;
        acc.loOff = pairBase;
        acc.hiOff = pairBase | 4'd1;
      end else if (oddOnly) begin
        acc.hiEn  = 1'b1;
        acc.hiOff = effOff;
      end else begin
        acc.loEn  = 1'b1;
        acc.loOff = off;
      end
    end

    if (!acc.rd && !acc.wr) acc.kind = ACC_NONE;
  end

endmodule

// File: rtl/cfdecPath.sv
module cfdecPath
  import cfdec_pkg::*;
#(
  parameter int BUF_BYTES = 512
) (
  input  logic        clk,
  input  logic        rstN,
  input  accStrobeT   acc,
  input  logic [15:0] dataIn,
  input  logic [7:0]  statusIn,
  input  logic [7:0]  errorIn,
  input  logic [7:0]  driveAddrIn,
  output logic [15:0] dataOut,
  output logic [8*TF_REGS-1:0] taskRegs,
  output logic [7:0]  features,
  output logic [7:0]  devCtl,
  output logic [7:0]  cmdCode,
  output logic        cmdValid
);

  localparam int WORDS  = BUF_BYTES / 2;
  localparam int WIDX_W = $clog2(WORDS);
  localparam int BIDX_W = WIDX_W + 1;
  localparam logic [WIDX_W-1:0] LAST_WORD = WIDX_W'(WORDS - 1);

  // ---------------- register file ----------------
  logic [7:0] tfView  [TF_REGS];
  logic [7:0] regView [NUM_OFF];
  logic       regWrEn [NUM_OFF];
  logic [7:0] regWrData [NUM_OFF];

  always_comb begin
    for (int o = 0; o < NUM_OFF; o++) begin
      regWrEn[o]   = 1'b0;
      regWrData[o] = 8'h00;
      if (acc.kind == ACC_REG && acc.wr) begin
        if (acc.loEn && acc.loOff == OFF_W'(o)) begin
          regWrEn[o]   = 1'b1;
          regWrData[o] = dataIn[7:0];
        end else if (acc.hiEn && acc.hiOff == OFF_W'(o)) begin
          regWrEn[o]   = 1'b1;
          regWrData[o] = dataIn[15:8];
        end
      end
    end
  end

  for (genvar g = 0; g < TF_REGS; g++) begin : g_tf
    logic [7:0] r;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                               r <= 8'h00;
      else if (regWrEn[int'(OFF_TFBASE) + g])  r <= regWrData[int'(OFF_TFBASE) + g];
    end
    assign tfView[g]           = r;
    assign taskRegs[8*g +: 8]  = r;
  end

  always_comb begin
    for (int o = 0; o < NUM_OFF; o++) regView[o] = 8'h00;
    for (int t = 0; t < TF_REGS; t++) regView[int'(OFF_TFBASE) + t] = tfView[t];
    regView[OFF_ERRFEAT] = errorIn;
    regView[OFF_DUPERR]  = errorIn;
    regView[OFF_STATCMD] = statusIn;
    regView[OFF_ALTCTL]  = statusIn;
    regView[OFF_DRVADR]  = driveAddrIn;
  end

  logic cmdWr;
  assign cmdWr = regWrEn[OFF_STATCMD];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      features <= 8'h00;
      devCtl   <= 8'h00;
      cmdCode  <= 8'h00;
      cmdValid <= 1'b0;
    end else begin
      cmdValid <= cmdWr;
      if (cmdWr)                  cmdCode  <= regWrData[OFF_STATCMD];
      if (regWrEn[OFF_ERRFEAT])   features <= regWrData[OFF_ERRFEAT];
      else if (regWrEn[OFF_DUPERR]) features <= regWrData[OFF_DUPERR];
      if (regWrEn[OFF_ALTCTL])    devCtl   <= regWrData[OFF_ALTCTL];
    end
  end

  // ---------------- sector buffer and pointer ----------------
  logic [7:0] secBuf [BUF_BYTES];
  logic [WIDX_W-1:0] wordIdx;
  logic evenDone, oddDone, bufEnd;

  logic [BIDX_W-1:0] evenAddr, oddAddr;
  logic dataGo, takeEven, takeOdd, nextEven, nextOdd, advance;
  logic [7:0] byteIn, evenWrData, oddWrData, evenRd, oddRd, pickRd;

  always_comb begin
    evenAddr   = {wordIdx, 1'b0};
    oddAddr    = {wordIdx, 1'b1};
    dataGo     = (acc.kind == ACC_DATA) && !bufEnd;
    takeEven   = (acc.mode == DM_WORD) || (acc.mode == DM_SEQ && !evenDone);
    takeOdd    = (acc.mode == DM_WORD) || (acc.mode == DM_ODD) ||
                 (acc.mode == DM_SEQ && evenDone);
    nextEven   = evenDone | takeEven;
    nextOdd    = oddDone | takeOdd;
    advance    = nextEven && nextOdd;
    byteIn     = acc.laneHi ? dataIn[15:8] : dataIn[7:0];
    evenWrData = (acc.mode == DM_WORD) ? dataIn[7:0]  : byteIn;
    oddWrData  = (acc.mode == DM_WORD) ? dataIn[15:8] : byteIn;
    evenRd     = secBuf[evenAddr];
    oddRd      = secBuf[oddAddr];
    pickRd     = takeOdd ? oddRd : evenRd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordIdx  <= '0;
      evenDone <= 1'b0;
      oddDone  <= 1'b0;
      bufEnd   <= 1'b0;
    end else if (cmdWr) begin
      wordIdx  <= '0;
      evenDone <= 1'b0;
      oddDone  <= 1'b0;
      bufEnd   <= 1'b0;
    end else if (dataGo) begin
      if (advance) begin
        wordIdx  <= wordIdx + 1'b1;
        evenDone <= 1'b0;
        oddDone  <= 1'b0;
        if (wordIdx == LAST_WORD) bufEnd <= 1'b1;
      end else begin
        evenDone <= nextEven;
        oddDone  <= nextOdd;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (dataGo && acc.wr) begin
      if (takeEven) secBuf[evenAddr] <= evenWrData;
      if (takeOdd)  secBuf[oddAddr]  <= oddWrData;
    end
  end

  // ---------------- read return ----------------
  logic [15:0] rdValue;

  always_comb begin
    rdValue = 16'h0000;
    if (acc.kind == ACC_DATA) begin
      if (!bufEnd) begin
        if (acc.mode == DM_WORD) rdValue = {oddRd, evenRd};
        else if (acc.laneHi)     rdValue = {pickRd, 8'h00};
        else                     rdValue = {8'h00, pickRd};
      end
    end else if (acc.kind == ACC_REG) begin
      rdValue = {acc.hiEn ? regView[acc.hiOff] : 8'h00,
                 acc.loEn ? regView[acc.loOff] : 8'h00};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       dataOut <= 16'h0000;
    else if (acc.rd) dataOut <= rdValue;
  end

endmodule

// File: rtl/cfTaskDecoder.sv
module cfTaskDecoder
  import cfdec_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int BUF_BYTES = 512
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              regN,
  input  logic              ce1N,
  input  logic              ce2N,
  input  logic              oeN,
  input  logic              weN,
  input  logic [15:0]       dataIn,
  input  logic [7:0]        statusIn,
  input  logic [7:0]        errorIn,
  input  logic [7:0]        driveAddrIn,
  output logic [15:0]       dataOut,
  output logic [39:0]       taskRegs,
  output logic [7:0]        features,
  output logic [7:0]        devCtl,
  output logic [7:0]        cmdCode,
  output logic              cmdValid
);

  accStrobeT acc;

  cfdecCtrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .regN(regN),
    .ce1N(ce1N), .ce2N(ce2N), .oeN(oeN), .weN(weN), .acc(acc)
  );

  cfdecPath #(.BUF_BYTES(BUF_BYTES)) u_path (
    .clk(clk), .rstN(rstN), .acc(acc), .dataIn(dataIn),
    .statusIn(statusIn), .errorIn(errorIn), .driveAddrIn(driveAddrIn),
    .dataOut(dataOut), .taskRegs(taskRegs), .features(features),
    .devCtl(devCtl), .cmdCode(cmdCode), .cmdValid(cmdValid)
  );

endmodule

// File: rtl/cfdecChecker.sv
module cfdecChecker #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic              regN,
  input logic              ce1N,
  input logic              ce2N,
  input logic              oeN,
  input logic              weN,
  input logic [15:0]       dataOut,
  input logic [39:0]       taskRegs,
  input logic [7:0]        features,
  input logic [7:0]        devCtl,
  input logic              cmdValid
);

  logic oePrevC, wePrevC;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oePrevC <= 1'b1;
      wePrevC <= 1'b1;
    end else begin
      oePrevC <= oeN;
      wePrevC <= weN;
    end
  end

  logic rdFall, wrFall, lowByteRsvd;
  assign rdFall = oePrevC && !oeN;
  assign wrFall = wePrevC && !weN;
  assign lowByteRsvd = regN && !ce1N && ce2N && !addr[ADDR_W-1] &&
                       (addr[3:0] inside {4'hA, 4'hB, 4'hC});

  assert_read_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !rdFall |=> $stable(dataOut));

  assert_cmd_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid);

  assert_cmd_cause_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cmdValid) |-> $past(wrFall && regN));

  assert_attr_ignored_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!regN && wrFall) |=> ($stable(taskRegs) && $stable(features) && $stable(devCtl)));

  assert_window_data_R9: assert property (@(posedge clk) disable iff (!rstN)
    (regN && addr[ADDR_W-1] && wrFall) |=> ($stable(taskRegs) && $stable(features)));

  assert_reserved_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rdFall && weN && lowByteRsvd) |=> (dataOut == 16'h0000));

endmodule

bind cfTaskDecoder cfdecChecker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .addr(addr), .regN(regN), .ce1N(ce1N),
  .ce2N(ce2N), .oeN(oeN), .weN(weN), .dataOut(dataOut),
  .taskRegs(taskRegs), .features(features), .devCtl(devCtl),
  .cmdValid(cmdValid)
);

// File: tb/sim_cfTaskDecoder.sv
module sim_cfTaskDecoder;

  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] WORD = 2'b00;  // {ce2N, ce1N}
  localparam logic [1:0] LOB  = 2'b10;
  localparam logic [1:0] HIB  = 2'b01;
  localparam logic [1:0] NONE = 2'b11;

  typedef struct packed {
    logic        wr;
    logic        rg;
    logic [1:0]  cs;
    logic [10:0] a;
    logic [15:0] wd;
    logic [15:0] exp;
    logic [3:0]  req;
  } vecT;

  localparam int NV = 52;
  localparam vecT VECS [NV] = '{
    '{1'b1,1'b1,LOB, 11'h002,16'h0011,16'h0000,4'd1},  // R1
    '{1'b1,1'b1,LOB, 11'h3F3,16'h0022,16'h0000,4'd1},  // R1 A9..A4 ignored
    '{1'b1,1'b1,LOB, 11'h004,16'h0033,16'h0000,4'd1},
    '{1'b1,1'b1,LOB, 11'h005,16'h0044,16'h0000,4'd1},
    '{1'b1,1'b1,LOB, 11'h006,16'h00E5,16'h0000,4'd1},
    '{1'b0,1'b1,LOB, 11'h002,16'h0000,16'h0011,4'd1},
    '{1'b0,1'b1,LOB, 11'h0F3,16'h0000,16'h0022,4'd1},
    '{1'b0,1'b1,WORD,11'h004,16'h0000,16'h4433,4'd1},
    '{1'b0,1'b1,LOB, 11'h006,16'h0000,16'h00E5,4'd1},
    '{1'b0,1'b1,LOB, 11'h007,16'h0000,16'h0058,4'd2},  // R2 status
    '{1'b0,1'b1,LOB, 11'h00E,16'h0000,16'h0058,4'd2},
    '{1'b0,1'b1,LOB, 11'h001,16'h0000,16'h0004,4'd2},
    '{1'b0,1'b1,LOB, 11'h00D,16'h0000,16'h0004,4'd2},
    '{1'b0,1'b1,LOB, 11'h00F,16'h0000,16'h00A7,4'd2},
    '{1'b1,1'b1,LOB, 11'h00B,16'h00FF,16'h0000,4'd4},  // R4 reserved
    '{1'b0,1'b1,LOB, 11'h00B,16'h0000,16'h0000,4'd4},
    '{1'b0,1'b1,LOB, 11'h00A,16'h0000,16'h0000,4'd4},
    '{1'b1,1'b1,LOB, 11'h00F,16'h00FF,16'h0000,4'd4},
    '{1'b0,1'b1,LOB, 11'h00F,16'h0000,16'h00A7,4'd4},
    '{1'b0,1'b1,HIB, 11'h000,16'h0000,16'h0400,4'd8},  // R8 error on high lane
    '{1'b1,1'b1,LOB, 11'h007,16'h0030,16'h0000,4'd3},  // R3 command
    '{1'b1,1'b1,WORD,11'h000,16'h0201,16'h0000,4'd5},  // R5
    '{1'b1,1'b1,WORD,11'h008,16'h0403,16'h0000,4'd5},
    '{1'b1,1'b1,WORD,11'h009,16'h0605,16'h0000,4'd5},
    '{1'b1,1'b1,LOB, 11'h000,16'h0007,16'h0000,4'd6},  // R6
    '{1'b1,1'b1,LOB, 11'h008,16'h0008,16'h0000,4'd6},
    '{1'b1,1'b1,LOB, 11'h008,16'h0009,16'h0000,4'd7},  // R7 8 then 9
    '{1'b1,1'b1,LOB, 11'h009,16'h000A,16'h0000,4'd7},
    '{1'b1,1'b1,LOB, 11'h009,16'h000C,16'h0000,4'd7},  // R7 9 then 8
    '{1'b1,1'b1,LOB, 11'h008,16'h000B,16'h0000,4'd7},
    '{1'b1,1'b1,HIB, 11'h008,16'h0E00,16'h0000,4'd8},  // R8 odd lane
    '{1'b1,1'b1,LOB, 11'h400,16'h000D,16'h0000,4'd9},  // R9 window
    '{1'b1,1'b1,LOB, 11'h7FF,16'h0010,16'h0000,4'd9},
    '{1'b1,1'b1,LOB, 11'h5F2,16'h000F,16'h0000,4'd9},
    '{1'b1,1'b1,LOB, 11'h007,16'h0020,16'h0000,4'd3},
    '{1'b0,1'b1,WORD,11'h000,16'h0000,16'h0201,4'd5},
    '{1'b0,1'b1,WORD,11'h408,16'h0000,16'h0403,4'd9},
    '{1'b0,1'b1,WORD,11'h009,16'h0000,16'h0605,4'd5},
    '{1'b0,1'b1,LOB, 11'h000,16'h0000,16'h0007,4'd6},
    '{1'b0,1'b1,LOB, 11'h008,16'h0000,16'h0008,4'd6},
    '{1'b0,1'b1,LOB, 11'h008,16'h0000,16'h0009,4'd7},
    '{1'b0,1'b1,LOB, 11'h009,16'h0000,16'h000A,4'd7},
    '{1'b0,1'b1,LOB, 11'h009,16'h0000,16'h000C,4'd7},
    '{1'b0,1'b1,LOB, 11'h008,16'h0000,16'h000B,4'd7},
    '{1'b0,1'b1,HIB, 11'h008,16'h0000,16'h0E00,4'd8},
    '{1'b0,1'b1,LOB, 11'h400,16'h0000,16'h000D,4'd9},
    '{1'b0,1'b1,LOB, 11'h401,16'h0000,16'h0010,4'd9},
    '{1'b0,1'b1,LOB, 11'h7FE,16'h0000,16'h000F,4'd9},
    '{1'b1,1'b0,LOB, 11'h002,16'h0099,16'h0000,4'd11}, // R11 attribute space
    '{1'b1,1'b1,NONE,11'h002,16'h0088,16'h0000,4'd11}, // R11 no enable
    '{1'b0,1'b1,LOB, 11'h002,16'h0000,16'h0011,4'd11},
    '{1'b0,1'b1,WORD,11'h002,16'h0000,16'h2211,4'd1}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [10:0] addr = '0;
  logic        regN = 1'b1, ce1N = 1'b1, ce2N = 1'b1, oeN = 1'b1, weN = 1'b1;
  logic [15:0] dataIn = '0;
  logic [7:0]  statusIn = 8'h58, errorIn = 8'h04, driveAddrIn = 8'hA7;
  logic [15:0] dataOut;
  logic [39:0] taskRegs;
  logic [7:0]  features, devCtl, cmdCode;
  logic        cmdValid;

  int checks = 0;
  int fails = 0;
  logic [15:0] rdSeen;
  logic        cmdSeen;
  logic [7:0]  cmdCodeSeen;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfTaskDecoder u0 (
    .clk(clk), .rstN(rstN), .addr(addr), .regN(regN), .ce1N(ce1N),
    .ce2N(ce2N), .oeN(oeN), .weN(weN), .dataIn(dataIn),
    .statusIn(statusIn), .errorIn(errorIn), .driveAddrIn(driveAddrIn),
    .dataOut(dataOut), .taskRegs(taskRegs), .features(features),
    .devCtl(devCtl), .cmdCode(cmdCode), .cmdValid(cmdValid)
  );

  task automatic check(input logic ok, input int req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL R%0d: actual %h expected %h", req, act, exp);
    end
  endtask

  // strobe held low over two edges: only the first may act (R11)
  task automatic hostAccess(input logic wr, input logic rg, input logic [1:0] cs,
                            input logic [10:0] a, input logic [15:0] wd);
    @(negedge clk);
    addr = a; regN = rg; {ce2N, ce1N} = cs; dataIn = wd;
    @(negedge clk);
    if (wr) weN = 1'b0; else oeN = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rdSeen = dataOut; cmdSeen = cmdValid; cmdCodeSeen = cmdCode;
    @(posedge clk);
    @(negedge clk);
    weN = 1'b1; oeN = 1'b1;
    @(negedge clk);
    {ce2N, ce1N} = NONE; regN = 1'b1;
  endtask

  bit finished = 1'b0;

  task automatic finish();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      finish();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R12 reset state
    check(dataOut == 16'h0 && taskRegs == 40'h0, 12, {dataOut, taskRegs}, 64'h0);
    check(features == 0 && devCtl == 0 && cmdCode == 0 && !cmdValid, 12,
          {features, devCtl, cmdCode, 7'h0, cmdValid}, 64'h0);

    for (int i = 0; i < NV; i++) begin
      hostAccess(VECS[i].wr, VECS[i].rg, VECS[i].cs, VECS[i].a, VECS[i].wd);
      if (!VECS[i].wr)
        check(rdSeen == VECS[i].exp, int'(VECS[i].req), 64'(rdSeen), 64'(VECS[i].exp));
    end

    // R1 export of task registers
    check(taskRegs == 40'hE5_44_33_22_11, 1, 64'(taskRegs), 64'hE544332211);

    // R2 features via offsets 1 and D
    hostAccess(1'b1, 1'b1, LOB, 11'h001, 16'h005A);
    check(features == 8'h5A, 2, 64'(features), 64'h5A);
    hostAccess(1'b1, 1'b1, LOB, 11'h00D, 16'h006B);
    check(features == 8'h6B, 2, 64'(features), 64'h6B);
    // R8 high-lane write at address 0 reaches features
    hostAccess(1'b1, 1'b1, HIB, 11'h000, 16'h7700);
    check(features == 8'h77, 8, 64'(features), 64'h77);
    // R4 device control
    hostAccess(1'b1, 1'b1, LOB, 11'h00E, 16'h0004);
    check(devCtl == 8'h04, 4, 64'(devCtl), 64'h04);
    // R3 command pulse
    hostAccess(1'b1, 1'b1, LOB, 11'h007, 16'h00EC);
    check(cmdSeen == 1'b1 && cmdCodeSeen == 8'hEC, 3, {cmdSeen, cmdCodeSeen}, {1'b1, 8'hEC});
    check(cmdValid == 1'b0, 3, 64'(cmdValid), 64'h0);

    // R10 fill the sector, overrun, then read back
    for (int w = 0; w < 256; w++)
      hostAccess(1'b1, 1'b1, WORD, 11'h000, 16'(w + 16'h0100));
    hostAccess(1'b1, 1'b1, WORD, 11'h000, 16'hFFFF);
    hostAccess(1'b1, 1'b1, LOB, 11'h008, 16'h00EE);
    hostAccess(1'b0, 1'b1, WORD, 11'h000, 16'h0000);
    check(rdSeen == 16'h0000, 10, 64'(rdSeen), 64'h0);
    hostAccess(1'b1, 1'b1, LOB, 11'h007, 16'h0020);
    for (int w = 0; w < 256; w++) begin
      hostAccess(1'b0, 1'b1, WORD, 11'h000, 16'h0000);
      check(rdSeen == 16'(w + 16'h0100), 10, 64'(rdSeen), 64'(w + 16'h0100));
    end
    hostAccess(1'b0, 1'b1, LOB, 11'h000, 16'h0000);
    check(rdSeen == 16'h0000, 10, 64'(rdSeen), 64'h0);

    finished = 1'b1;
    finish();
  end

endmodule